// File: doc/BRIEF.md
# Processor Bus Data Tenure Controller

This block runs the data side of a bus master on a split-transaction processor bus, where address and data tenures are arbitrated separately. When the master's own transfer start carries a data request, the block holds that request pending. It then waits for a data bus grant that is not cancelled by an address retry and that arrives while the data bus is free. When such a grant comes, it claims the bus by driving the active-low busy line.

While it owns the bus, the block counts the beats the slave acknowledges. A beat is acknowledged by either transfer acknowledge or data-valid. After the last beat the block releases the bus. The busy state is kept inside the block from its own start, grant and termination inputs, so arbitration works on buses that have no shared busy wire.

A retry that arrives before the first beat aborts the tenure, and the request is reissued. Any acknowledge seen less than two clocks after a transfer start sets a sticky protocol error.

Top module: `data_tenure_ctrl`

## Requirements
- R1: After reset, and after any later reset, `dbusy_n` is 1, `tenure_active` is 0, `beat_count` is 0, `tenure_done` is 0 and `early_ack_err` is 0. No request is pending, so a grant on its own starts no tenure.
- R2: A request is recorded only in a cycle where `xfer_start_n` is 0 and `xfer_type3` is 1. A start with `xfer_type3` at 0 leaves the block idle, even when a grant follows.
- R3: A grant qualifies only in a cycle where a request is pending, `dgrant_n` is 0, `retry_n` is 1 and the internal busy state is clear. At the next clock edge `dbusy_n` goes to 0, `tenure_active` goes to 1 and `beat_count` clears to 0. A grant given while `retry_n` is 0 is ignored.
- R4: Each edge with `tenure_active` at 1 and `xack_n` or `dvalid_n` at 0 adds one to `beat_count`. On the edge that takes the final beat, `dbusy_n` returns to 1, `tenure_active` to 0, and `tenure_done` pulses for exactly one cycle. `beat_count` then holds the final count.
- R5: `burst_req` is sampled with the request: 1 selects a 4-beat tenure and 0 selects a single beat.
- R6: If `dgrant_n` stays at 0 after a tenure ends and a request is pending, that grant starts a new tenure. `dbusy_n` goes low again on the second edge after the `tenure_done` edge.
- R7: A retry (`retry_n` at 0) while `tenure_active` is 1 and `beat_count` is 0 ends the tenure at the next edge without a `tenure_done` pulse. The request, including its burst length, stays pending and is reissued on a later qualified grant.
- R8: An acknowledge seen in the same cycle as a data request, or in the cycle after it, sets `early_ack_err`. An acknowledge two or more cycles after the request does not set it. An acknowledge outside a tenure does not change `beat_count`.
- R9: `early_ack_err` stays at 1 until a cycle with `err_clear` at 1 clears it at the next edge, unless a new early acknowledge arrives in that same cycle.
- R10: The internal busy state covers the owned tenure and the one cycle after it ends. A request made during a tenure waits in the pending slot and starts only after that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| xfer_start_n | input | 1 | Transfer start of this master, active low |
| xfer_type3 | input | 1 | Transfer type bit 3; 1 means a data tenure is needed |
| burst_req | input | 1 | 1 selects a 4-beat tenure, sampled with the request |
| dgrant_n | input | 1 | Data bus grant, active low |
| retry_n | input | 1 | Address retry, active low |
| xack_n | input | 1 | Transfer acknowledge from the slave, active low |
| dvalid_n | input | 1 | Data-valid beat termination, active low |
| err_clear | input | 1 | Synchronous clear of the early-acknowledge error |
| dbusy_n | output | 1 | Data bus busy, active low, driven while owning |
| tenure_active | output | 1 | 1 while this master owns the data bus |
| beat_count | output | 3 | Beats acknowledged in the current or last tenure |
| tenure_done | output | 1 | One-cycle pulse after the final beat |
| early_ack_err | output | 1 | Sticky error for an acknowledge that came too soon |

## Verification
Every result of this block is registered, so each one appears one edge after the cycle that causes it. The exception is a new tenure: it needs two edges after its request, one to record the request and one to take the grant. A held grant needs two edges after the done edge, because of the gap cycle. The bench drives each cycle's inputs at the falling edge and reads the outputs shortly after the next rising edge. Each expected value is therefore the state one edge after those inputs. The vector table lists expectations cycle by cycle, so the gap and the reissue after a retry are checked on the exact edge they are due.

// File: rtl/data_tenure_ctrl.sv
module data_tenure_ctrl #(
  parameter int BURST_BEATS = 4,
  parameter int MIN_ACK_GAP = 2,
  localparam int BW = $clog2(BURST_BEATS + 1),
  localparam int AW = $clog2(MIN_ACK_GAP + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          xfer_start_n,
  input  logic          xfer_type3,
  input  logic          burst_req,
  input  logic          dgrant_n,
  input  logic          retry_n,
  input  logic          xack_n,
  input  logic          dvalid_n,
  input  logic          err_clear,
  output logic          dbusy_n,
  output logic          tenure_active,
  output logic [BW-1:0] beat_count,
  output logic          tenure_done,
  output logic          early_ack_err
);

  logic          pend, pend_burst, own, cur_burst, gap;
  logic [AW-1:0] age;

  wire          ack        = !xack_n || !dvalid_n;
  wire          req        = !xfer_start_n && xfer_type3;
  wire          busy       = own || gap;
  wire          qual       = pend && !dgrant_n && retry_n && !busy;
  wire [BW-1:0] last_beat  = cur_burst ? BW'(BURST_BEATS) : BW'(1);
  wire          abort      = own && (beat_count == '0) && !retry_n;
  wire          beat_ev    = own && ack && !abort;
  wire          final_beat = beat_ev && ((beat_count + BW'(1)) == last_beat);
  wire          early      = ack && (req || (age < AW'(MIN_ACK_GAP)));

  assign dbusy_n       = ~own;
  assign tenure_active = own;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend          <= 1'b0;
      pend_burst    <= 1'b0;
      own           <= 1'b0;
      cur_burst     <= 1'b0;
      gap           <= 1'b0;
      beat_count    <= '0;
      age           <= AW'(MIN_ACK_GAP);
      tenure_done   <= 1'b0;
      early_ack_err <= 1'b0;
    end else begin
      gap         <= final_beat || abort;
      tenure_done <= final_beat;

      if (req) begin
        pend       <= 1'b1;
        pend_burst <= burst_req;
      end else if (qual) begin
        pend <= 1'b0;
      end else if (abort) begin
        pend       <= 1'b1;
        pend_burst <= cur_burst;
      end

      if (qual) begin
        own        <= 1'b1;
        cur_burst  <= pend_burst;
        beat_count <= '0;
      end else begin
        if (abort || final_beat) own <= 1'b0;
        if (beat_ev) beat_count <= beat_count + BW'(1);
      end

      if (req) age <= AW'(1);
      else if (age < AW'(MIN_ACK_GAP)) age <= age + AW'(1);

      if (early) early_ack_err <= 1'b1;
      else if (err_clear) early_ack_err <= 1'b0;
    end
  end

  assert_qual_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dbusy_n) |-> $past(!dgrant_n && retry_n));

  assert_release_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dbusy_n) |=> dbusy_n);

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tenure_done |=> !tenure_done);

  assert_done_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tenure_done |-> (dbusy_n && !tenure_active));

  assert_beat_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tenure_active |-> (beat_count < BW'(BURST_BEATS)));

  assert_retry_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tenure_active && beat_count == '0 && !retry_n) |=> (!tenure_active && !tenure_done));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (early_ack_err && !err_clear) |=> early_ack_err);

endmodule

// File: tb/test_data_tenure_ctrl.sv
`timescale 1ns/1ps
module test_data_tenure_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xfer_start_n = 1'b1, xfer_type3 = 1'b0, burst_req = 1'b0, dgrant_n = 1'b1;
  logic retry_n = 1'b1, xack_n = 1'b1, dvalid_n = 1'b1, err_clear = 1'b0;
  logic dbusy_n, tenure_active, tenure_done, early_ack_err;
  logic [2:0] beat_count;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  data_tenure_ctrl i_data_tenure_ctrl (
    .clk(clk), .rst_n(rst_n), .xfer_start_n(xfer_start_n), .xfer_type3(xfer_type3),
    .burst_req(burst_req), .dgrant_n(dgrant_n), .retry_n(retry_n), .xack_n(xack_n),
    .dvalid_n(dvalid_n), .err_clear(err_clear), .dbusy_n(dbusy_n),
    .tenure_active(tenure_active), .beat_count(beat_count), .tenure_done(tenure_done),
    .early_ack_err(early_ack_err));

  // {start_n,type3,burst,grant_n,retry_n,ack_n,dvalid_n, busy_n,active,beats[2:0],done}
  localparam int NV = 33;
  localparam logic [12:0] VEC [NV] = '{
    13'b0101111_100000, // R2 single request
    13'b1000111_010000, // R3 grant
    13'b1001110_100011, // R4 final beat
    13'b1001111_100010,
    13'b0111111_100010, // R5 burst request
    13'b1000111_010000,
    13'b1000110_010010,
    13'b1001110_010100,
    13'b0101111_010100, // R10 request during tenure
    13'b1001111_010100,
    13'b1001101_010110, // R4 dvalid beat
    13'b1001110_101001,
    13'b1000111_101000, // R10 gap blocks grant
    13'b1000111_010000, // R6 held grant new tenure
    13'b1000110_100011,
    13'b1001111_100010,
    13'b0111111_100010, // R7 burst then retry
    13'b1000111_010000,
    13'b1001011_100000, // R7 abort, no done
    13'b1001111_100000,
    13'b1000111_010000, // R7 reissue
    13'b1001110_010010,
    13'b1001110_010100,
    13'b1001110_010110,
    13'b1001110_101001, // R7 four beats kept
    13'b1001111_101000,
    13'b0101111_101000,
    13'b1000011_101000, // R3 grant with retry ignored
    13'b1000111_010000,
    13'b1001110_100011,
    13'b1001111_100010,
    13'b0001111_100010, // R2 type3 low
    13'b1000111_100010  // R2 grant gives nothing
  };

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(logic [6:0] s);
    {xfer_start_n, xfer_type3, burst_req, dgrant_n, retry_n, xack_n, dvalid_n} = s;
  endtask

  task automatic cyc(logic [6:0] s, logic clr = 1'b0);
    @(negedge clk);
    drive(s);
    err_clear = clr;
    @(posedge clk);
    #1;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 busy_n", dbusy_n, 1);
    check("R1 active", tenure_active, 0);
    check("R1 beats", beat_count, 0);
    check("R1 done", tenure_done, 0);
    check("R1 err", early_ack_err, 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i][12:6]);
      check($sformatf("R3/R4/R5/R6/R7/R10 vec%0d busy_n", i), dbusy_n, VEC[i][5]);
      check($sformatf("R3/R4/R5/R6/R7/R10 vec%0d active", i), tenure_active, VEC[i][4]);
      check($sformatf("R4/R5 vec%0d beats", i), beat_count, VEC[i][3:1]);
      check($sformatf("R4 vec%0d done", i), tenure_done, VEC[i][0]);
    end
    check("R8 no early in table", early_ack_err, 0);

    // R8 ack in the same cycle as the request
    cyc(7'b0101101);
    check("R8 same-cycle ack err", early_ack_err, 1);
    check("R8 ack outside tenure beats", beat_count, 1);
    cyc(7'b1001111);
    check("R9 sticky", early_ack_err, 1);
    cyc(7'b1001111, 1'b1);
    check("R9 clear", early_ack_err, 0);
    cyc(7'b1000111);
    check("R3 pending grant", tenure_active, 1);
    cyc(7'b1001110);
    check("R8 late ack no err", early_ack_err, 0);
    check("R4 done after late ack", tenure_done, 1);

    // R8 ack one cycle after the request
    cyc(7'b0101111);
    cyc(7'b1001101);
    check("R8 next-cycle ack err", early_ack_err, 1);
    cyc(7'b1000111, 1'b1);
    check("R9 clear again", early_ack_err, 0);
    check("R3 grant after early", tenure_active, 1);
    cyc(7'b1001110);
    check("R4 done", tenure_done, 1);

    // R1 reset during a tenure
    cyc(7'b0111111);
    cyc(7'b1000111);
    check("R3 active before reset", tenure_active, 1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 mid reset busy_n", dbusy_n, 1);
    check("R1 mid reset active", tenure_active, 0);
    check("R1 mid reset beats", beat_count, 0);
    @(negedge clk);
    rst_n = 1'b1;
    cyc(7'b1000111);
    cyc(7'b1000111);
    check("R1 no pending after reset", dbusy_n, 1);

    summary();
  end
endmodule